// File: doc/BRIEF.md
# Trap Entry and Return Sequencer

This block is the multi-cycle controller that a 32-bit load/store core uses to enter a trap or external interrupt and to leave it again. On entry it takes a snapshot of the program counter, the processor status word and the system status word. It pushes those three words onto the supervisor stack and clears the processor status word. It then reads a new program counter and a new system status word from a two-word vector in memory. The supervisor stack pointer moves down by three words.

The return operation reverses this. It pops the system status word, then the processor status word, then the program counter, and moves the supervisor stack pointer back up by three words. All memory traffic goes through one word-wide request/acknowledge port. Register updates leave the block as write strobes with data. The block also drives the register-bank select. The supervisor bank is forced for the whole sequence. Outside a sequence, the mode bit of the current system status word picks the bank.

Top module: `trap_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `mem_req`, `seq_done` and every register write strobe are low.
- R2: A trap entry writes the snapshot PC to SP-4, then the PSW to SP-8, then the SSW to SP-12, where SP is the supervisor stack pointer at the request. Each access holds until it is acknowledged.
- R3: After the three saves and before any vector read, the block writes zero to the PSW in one cycle with no memory access.
- R4: The new PC is read from the vector address, and the new SSW from the vector address plus 4, in that order.
- R5: The last vector read writes SP-12 to the supervisor stack pointer and pulses `seq_done`. An entry makes exactly five memory accesses.
- R6: A return reads the SSW from SP, the PSW from SP+4 and the PC from SP+8, in that order. It then writes SP+12 to the supervisor stack pointer and pulses `seq_done`, after exactly three memory accesses.
- R7: `reg_bank_sup` is high while `busy` is high. When idle it is the inverse of SSW bit 0, where 1 means user mode.
- R8: `busy` rises on the cycle after an accepted request and falls after the completing acknowledge. Trap or return requests made while busy have no effect.
- R9: When a trap request and a return request arrive in the same idle cycle, the trap entry is performed.
- R10: While `mem_req` waits for `mem_ack`, the request, address, write flag and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_req | input | 1 | Start trap entry (sampled when idle) |
| rti_req | input | 1 | Start return from interrupt (sampled when idle) |
| trap_vec_addr | input | 32 | Byte address of the two-word vector |
| cur_pc | input | 32 | Current program counter |
| cur_psw | input | 32 | Current processor status word |
| cur_ssw | input | 32 | Current system status word |
| cur_ssp | input | 32 | Current supervisor stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| pc_we | output | 1 | PC write strobe |
| pc_wdata | output | 32 | New PC |
| psw_we | output | 1 | PSW write strobe |
| psw_wdata | output | 32 | New PSW |
| ssw_we | output | 1 | SSW write strobe |
| ssw_wdata | output | 32 | New SSW |
| ssp_we | output | 1 | Supervisor stack pointer write strobe |
| ssp_wdata | output | 32 | New supervisor stack pointer |
| reg_bank_sup | output | 1 | 1 selects the supervisor register bank |
| busy | output | 1 | Sequence in progress |
| seq_done | output | 1 | One-cycle pulse on the completing acknowledge |

## Verification
The assertions assume that memory raises `mem_ack` only while `mem_req` is high, and for only one cycle per access. They also assume that the PSW is written with zero only in the clear step, since a popped PSW comes with an acknowledge. The bench memory model gives the acknowledge after a programmable number of wait states and drops it on the next cycle. It never acknowledges an idle port. The bench applies requests only as one-cycle pulses away from the clock edge.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  localparam int XLEN       = 32;
  localparam int WORD_BYTES = XLEN / 8;
  localparam int CTX_WORDS  = 3;

  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_PC,
    ST_PUSH_PSW,
    ST_PUSH_SSW,
    ST_CLR_PSW,
    ST_LD_PC,
    ST_LD_SSW,
    ST_POP_SSW,
    ST_POP_PSW,
    ST_POP_PC
  } seq_state_e;

  // predecrement push: slot n is (n+1) words below the starting pointer
  function automatic word_t push_slot(word_t sp, int unsigned n);
    return sp - word_t'(WORD_BYTES * (n + 1));
  endfunction

  // postincrement pop: slot n is n words above the starting pointer
  function automatic word_t pop_slot(word_t sp, int unsigned n);
    return sp + word_t'(WORD_BYTES * n);
  endfunction

  function automatic word_t vec_slot(word_t base, int unsigned n);
    return base + word_t'(WORD_BYTES * n);
  endfunction

  function automatic logic is_mem_state(seq_state_e s);
    return (s != ST_IDLE) && (s != ST_CLR_PSW);
  endfunction
endpackage

// File: rtl/trap_seq_fsm.sv
module trap_seq_fsm
  import trap_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trap_req,
  input  logic       rti_req,
  input  logic       mem_ack,
  output seq_state_e state,
  output logic       seq_start,
  output logic       step_ack
);
  seq_state_e nxt;

  assign seq_start = (state == ST_IDLE) && (trap_req || rti_req);
  assign step_ack  = is_mem_state(state) && mem_ack;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:     if (trap_req) nxt = ST_PUSH_PC;
                   else if (rti_req) nxt = ST_POP_SSW;
      ST_PUSH_PC:  if (mem_ack) nxt = ST_PUSH_PSW;
      ST_PUSH_PSW: if (mem_ack) nxt = ST_PUSH_SSW;
      ST_PUSH_SSW: if (mem_ack) nxt = ST_CLR_PSW;
      ST_CLR_PSW:  nxt = ST_LD_PC;
      ST_LD_PC:    if (mem_ack) nxt = ST_LD_SSW;
      ST_LD_SSW:   if (mem_ack) nxt = ST_IDLE;
      ST_POP_SSW:  if (mem_ack) nxt = ST_POP_PSW;
      ST_POP_PSW:  if (mem_ack) nxt = ST_POP_PC;
      ST_POP_PC:   if (mem_ack) nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/trap_seq_ctx.sv
module trap_seq_ctx
  import trap_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  seq_start,
  input  word_t trap_vec_addr,
  input  word_t cur_pc,
  input  word_t cur_psw,
  input  word_t cur_ssw,
  input  word_t cur_ssp,
  output word_t snap_pc,
  output word_t snap_psw,
  output word_t snap_ssw,
  output word_t snap_sp,
  output word_t snap_vec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_pc  <= '0;
      snap_psw <= '0;
      snap_ssw <= '0;
      snap_sp  <= '0;
      snap_vec <= '0;
    end else if (seq_start) begin
      snap_pc  <= cur_pc;
      snap_psw <= cur_psw;
      snap_ssw <= cur_ssw;
      snap_sp  <= cur_ssp;
      snap_vec <= trap_vec_addr;
    end
  end
endmodule

// File: rtl/trap_seq_port.sv
module trap_seq_port
  import trap_seq_pkg::*;
(
  input  seq_state_e state,
  input  word_t      snap_pc,
  input  word_t      snap_psw,
  input  word_t      snap_ssw,
  input  word_t      snap_sp,
  input  word_t      snap_vec,
  output logic       mem_req,
  output logic       mem_we,
  output word_t      mem_addr,
  output word_t      mem_wdata
);
  always_comb begin
    mem_req   = is_mem_state(state);
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      ST_PUSH_PC:  begin mem_we = 1'b1; mem_addr = push_slot(snap_sp, 0); mem_wdata = snap_pc;  end
      ST_PUSH_PSW: begin mem_we = 1'b1; mem_addr = push_slot(snap_sp, 1); mem_wdata = snap_psw; end
      ST_PUSH_SSW: begin mem_we = 1'b1; mem_addr = push_slot(snap_sp, 2); mem_wdata = snap_ssw; end
      ST_LD_PC:    mem_addr = vec_slot(snap_vec, 0);
      ST_LD_SSW:   mem_addr = vec_slot(snap_vec, 1);
      ST_POP_SSW:  mem_addr = pop_slot(snap_sp, 0);
      ST_POP_PSW:  mem_addr = pop_slot(snap_sp, 1);
      ST_POP_PC:   mem_addr = pop_slot(snap_sp, 2);
      default:     ;
    endcase
  end
endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_seq_pkg::*;
#(
  parameter int USER_BIT = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_req,
  input  logic            rti_req,
  input  logic [XLEN-1:0] trap_vec_addr,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] cur_psw,
  input  logic [XLEN-1:0] cur_ssw,
  input  logic [XLEN-1:0] cur_ssp,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_ack,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            pc_we,
  output logic [XLEN-1:0] pc_wdata,
  output logic            psw_we,
  output logic [XLEN-1:0] psw_wdata,
  output logic            ssw_we,
  output logic [XLEN-1:0] ssw_wdata,
  output logic            ssp_we,
  output logic [XLEN-1:0] ssp_wdata,
  output logic            reg_bank_sup,
  output logic            busy,
  output logic            seq_done
);
  seq_state_e state;
  logic       seq_start;
  logic       step_ack;
  word_t      snap_pc, snap_psw, snap_ssw, snap_sp, snap_vec;
  logic       entry_end, return_end;

  trap_seq_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .rti_req(rti_req),
    .mem_ack(mem_ack), .state(state), .seq_start(seq_start), .step_ack(step_ack)
  );

  trap_seq_ctx ctx_i (
    .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .trap_vec_addr(trap_vec_addr),
    .cur_pc(cur_pc), .cur_psw(cur_psw), .cur_ssw(cur_ssw), .cur_ssp(cur_ssp),
    .snap_pc(snap_pc), .snap_psw(snap_psw), .snap_ssw(snap_ssw),
    .snap_sp(snap_sp), .snap_vec(snap_vec)
  );

  trap_seq_port port_i (
    .state(state), .snap_pc(snap_pc), .snap_psw(snap_psw), .snap_ssw(snap_ssw),
    .snap_sp(snap_sp), .snap_vec(snap_vec),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  assign entry_end  = step_ack && (state == ST_LD_SSW);
  assign return_end = step_ack && (state == ST_POP_PC);

  assign busy     = (state != ST_IDLE);
  assign seq_done = entry_end || return_end;

  assign pc_we     = step_ack && ((state == ST_LD_PC) || (state == ST_POP_PC));
  assign pc_wdata  = mem_rdata;
  assign ssw_we    = step_ack && ((state == ST_LD_SSW) || (state == ST_POP_SSW));
  assign ssw_wdata = mem_rdata;
  assign psw_we    = (state == ST_CLR_PSW) || (step_ack && (state == ST_POP_PSW));
  assign psw_wdata = (state == ST_CLR_PSW) ? '0 : mem_rdata;
  assign ssp_we    = seq_done;
  assign ssp_wdata = entry_end ? push_slot(snap_sp, CTX_WORDS - 1)
                               : pop_slot(snap_sp, CTX_WORDS);

  assign reg_bank_sup = busy || !cur_ssw[USER_BIT];
endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk
  import trap_seq_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  seq_start,
  input logic  busy,
  input logic  seq_done,
  input logic  mem_req,
  input logic  mem_we,
  input word_t mem_addr,
  input word_t mem_wdata,
  input logic  mem_ack,
  input logic  pc_we,
  input logic  psw_we,
  input word_t psw_wdata,
  input logic  ssw_we,
  input logic  reg_bank_sup
);
  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R8
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> busy);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !busy);

  // R7
  bank_sup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> reg_bank_sup);

  // R3
  psw_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psw_we && !mem_req |-> psw_wdata == '0);

  // R2
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pc_we, psw_we, ssw_we}));
endmodule

bind trap_seq trap_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .busy(busy), .seq_done(seq_done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .pc_we(pc_we), .psw_we(psw_we), .psw_wdata(psw_wdata),
  .ssw_we(ssw_we), .reg_bank_sup(reg_bank_sup)
);

// File: tb/trap_seq_tb_top.sv
`timescale 1ns/100ps
module trap_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        trap_req = 1'b0, rti_req = 1'b0;
  logic [31:0] vec_addr = '0;
  logic [31:0] r_pc, r_psw, r_ssw, r_ssp;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        pc_we, psw_we, ssw_we, ssp_we;
  logic [31:0] pc_wdata, psw_wdata, ssw_wdata, ssp_wdata;
  logic        bank_sup, busy, seq_done;

  trap_seq dut_i (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .rti_req(rti_req),
    .trap_vec_addr(vec_addr), .cur_pc(r_pc), .cur_psw(r_psw), .cur_ssw(r_ssw),
    .cur_ssp(r_ssp), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .pc_we(pc_we), .pc_wdata(pc_wdata), .psw_we(psw_we), .psw_wdata(psw_wdata),
    .ssw_we(ssw_we), .ssw_wdata(ssw_wdata), .ssp_we(ssp_we), .ssp_wdata(ssp_wdata),
    .reg_bank_sup(bank_sup), .busy(busy), .seq_done(seq_done)
  );

  // bench-side register file and memory, loaded through a bench port
  logic        ld_regs = 1'b0, ld_mem = 1'b0;
  logic [31:0] ld_pc, ld_psw, ld_ssw, ld_ssp, ld_dat;
  logic [5:0]  ld_idx;
  logic [31:0] mem [64];
  logic [3:0]  lat = '0, wcnt;
  int          ack_cnt;

  always @(posedge clk) begin
    if (ld_regs) begin
      r_pc <= ld_pc; r_psw <= ld_psw; r_ssw <= ld_ssw; r_ssp <= ld_ssp;
    end else begin
      if (pc_we)  r_pc  <= pc_wdata;
      if (psw_we) r_psw <= psw_wdata;
      if (ssw_we) r_ssw <= ssw_wdata;
      if (ssp_we) r_ssp <= ssp_wdata;
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; wcnt <= '0; mem_rdata <= '0; ack_cnt <= 0;
    end else begin
      if (ld_mem) mem[ld_idx] <= ld_dat;
      if (mem_req && !mem_ack) begin
        if (wcnt == lat) begin
          mem_ack <= 1'b1; wcnt <= '0; ack_cnt <= ack_cnt + 1;
          mem_rdata <= mem[mem_addr[7:2]];
          if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
        end else wcnt <= wcnt + 1'b1;
      end else begin
        mem_ack <= 1'b0;
      end
    end
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load_regs(input logic [31:0] pc, psw, ssw, ssp);
    @(negedge clk);
    ld_pc = pc; ld_psw = psw; ld_ssw = ssw; ld_ssp = ssp; ld_regs = 1'b1;
    @(negedge clk);
    ld_regs = 1'b0;
  endtask

  task automatic poke(input logic [31:0] addr, input logic [31:0] dat);
    @(negedge clk);
    ld_idx = addr[7:2]; ld_dat = dat; ld_mem = 1'b1;
    @(negedge clk);
    ld_mem = 1'b0;
  endtask

  task automatic pulse(input logic t, input logic r);
    @(negedge clk);
    trap_req = t; rti_req = r;
    @(negedge clk);
    trap_req = 1'b0; rti_req = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // {sp, vec, pc, psw, ssw, wait states}
  localparam int NV = 6;
  localparam logic [115:0] VECS [NV] = '{
    {8'h80, 8'h10, 32'h0000_1234, 32'hA5A5_0001, 32'h0000_0001, 4'd0},
    {8'hC0, 8'h20, 32'hDEAD_BEEC, 32'h0000_00FF, 32'h0000_0041, 4'd1},
    {8'hF0, 8'h08, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 4'd3},
    {8'h70, 8'h30, 32'h1357_9BDE, 32'h1111_2222, 32'h8000_0003, 4'd2},
    {8'hA0, 8'h00, 32'h0000_0004, 32'h0000_0000, 32'h0000_0010, 4'd5},
    {8'hE4, 8'h38, 32'hCAFE_F00C, 32'h7070_7070, 32'hFFFF_FFFF, 4'd0}
  };

  initial begin
    #50000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] sp, vec, pc, psw, ssw, npc, nssw;
    int a0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 strobes", {27'd0, pc_we, psw_we, ssw_we, ssp_we, seq_done}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      sp = {24'd0, VECS[i][115:108]}; vec = {24'd0, VECS[i][107:100]};
      pc = VECS[i][99:68]; psw = VECS[i][67:36]; ssw = VECS[i][35:4];
      lat = VECS[i][3:0];
      npc = 32'h4000_0000 + 32'(i * 16); nssw = 32'h0000_0A00 | 32'(i * 2);
      vec_addr = vec;
      poke(vec, npc); poke(vec + 4, nssw);
      load_regs(pc, psw, ssw, sp);
      chk("R7 idle bank", {31'd0, bank_sup}, {31'd0, ~ssw[0]});
      a0 = ack_cnt;
      pulse(1'b1, 1'b0);
      chk("R8 busy after req", {31'd0, busy}, 32'd1);
      chk("R7 bank during entry", {31'd0, bank_sup}, 32'd1);
      wait_idle();
      chk("R2 pc slot", mem[sp[7:2] - 6'd1], pc);
      chk("R2 psw slot", mem[sp[7:2] - 6'd2], psw);
      chk("R2 ssw slot", mem[sp[7:2] - 6'd3], ssw);
      chk("R3 psw cleared", r_psw, 32'd0);
      chk("R4 new pc", r_pc, npc);
      chk("R4 new ssw", r_ssw, nssw);
      chk("R5 ssp", r_ssp, sp - 12);
      chk("R5 accesses", 32'(ack_cnt - a0), 32'd5);
      a0 = ack_cnt;
      pulse(1'b0, 1'b1);
      wait_idle();
      chk("R6 pc", r_pc, pc);
      chk("R6 psw", r_psw, psw);
      chk("R6 ssw", r_ssw, ssw);
      chk("R6 ssp", r_ssp, sp);
      chk("R6 accesses", 32'(ack_cnt - a0), 32'd3);
      chk("R7 bank after return", {31'd0, bank_sup}, {31'd0, ~ssw[0]});
    end

    // R9 simultaneous requests: entry wins
    lat = 4'd1; vec_addr = 32'h10;
    poke(32'h10, 32'h0000_5550); poke(32'h14, 32'h0000_0002);
    load_regs(32'h0000_0100, 32'h0000_00CC, 32'h0000_0001, 32'h0000_0090);
    a0 = ack_cnt;
    pulse(1'b1, 1'b1);
    wait_idle();
    chk("R9 accesses", 32'(ack_cnt - a0), 32'd5);
    chk("R9 pc from vector", r_pc, 32'h0000_5550);
    chk("R9 psw cleared", r_psw, 32'd0);

    // R8 requests while busy are ignored
    a0 = ack_cnt;
    pulse(1'b1, 1'b0);
    repeat (2) @(negedge clk);
    pulse(1'b1, 1'b1);
    wait_idle();
    repeat (10) @(negedge clk);
    chk("R8 busy drops", {31'd0, busy}, 32'd0);
    chk("R8 one entry only", 32'(ack_cnt - a0), 32'd5);
    chk("R8 ssp one frame", r_ssp, 32'h0000_0090 - 24);
    a0 = ack_cnt;
    pulse(1'b0, 1'b1);
    @(negedge clk);
    pulse(1'b0, 1'b1);
    wait_idle();
    repeat (10) @(negedge clk);
    chk("R8 one return only", 32'(ack_cnt - a0), 32'd3);
    chk("R8 ssp after return", r_ssp, 32'h0000_0090 - 12);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule